// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Channel

This block is a single timer channel that watches a shared, free-running main tick counter. It holds its own comparator value and emits a one-cycle event pulse when the counter reaches that value. The channel is either one-shot or periodic. In periodic mode the comparator moves forward by a stored period after each event, so events recur at a fixed tick spacing. The channel works at either the full 64-bit width or a narrow 32-bit width. In narrow mode the stored values and the compare use only the low 32 bits.

Software reaches the channel through a single comparator write port. In periodic mode, a self-clearing "set-value" flag decides whether that write reloads the comparator or sets the period. A period write is made safe before it is stored: its top bit is cleared, and it is raised to a minimum tick count. If the counter has already passed the advanced comparator (for example after a counter jump), the channel steps the comparator forward one period per clock. No event fires until the comparator is strictly ahead of the counter, using a wrap-aware compare. A global run input gates all events. The routing of the event and the register decoding sit outside this block.

Top module: `cmp_channel`

## Requirements
- R1: After reset, cmp_o is all ones, period_o is zero, setval_o is 0 and fire_o is 0.
- R2: fire_o pulses high for exactly one clock, starting one clock after an edge at which run_i is 1, no catch-up is in progress, and count_i equals cmp_o over the active width (the low 32 bits when narrow_i is 1, all 64 bits otherwise).
- R3: While count_i holds one value that matches the comparator, the channel fires at most once.
- R4: While run_i is 0, no event fires. When run_i returns to 1 and the counter already equals the comparator, one event fires.
- R5: A comparator write (cmp_wr_i) loads cmp_o with the write data when periodic_i is 0 or when setval_o is 1.
- R6: A comparator write with periodic_i 1 and setval_o 0 leaves cmp_o alone and stores a period. The data's top bit at the active width (bit 63 wide, bit 31 narrow) is cleared first, and the value is then raised to MIN_PERIOD if it is smaller.
- R7: A setval_i pulse sets setval_o to 1. Any comparator write clears it, and the clear wins over a set in the same cycle.
- R8: When a periodic channel with a nonzero period fires, the comparator advances by the period once per clock until it is strictly after the counter (signed difference at the active width). No event fires during this catch-up. With a zero period, the comparator does not move.
- R9: While narrow_i is 1, the stored comparator and period have their upper 32 bits forced to zero from the next clock on. Write data is truncated the same way, and comparator sums wrap at 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Global enable for events |
| periodic_i | input | 1 | 1 = periodic mode, 0 = one-shot |
| narrow_i | input | 1 | 1 = 32-bit operation, 0 = 64-bit |
| setval_i | input | 1 | Pulse that arms the set-value flag |
| cmp_wr_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | 64 | Comparator write data |
| count_i | input | 64 | Shared main counter value |
| fire_o | output | 1 | One-cycle event pulse |
| setval_o | output | 1 | Current set-value flag |
| cmp_o | output | 64 | Current comparator |
| period_o | output | 64 | Current period |

## Verification
The event pulse is registered. It appears one clock after the edge that sees the match, so the monitor compares each pulse with the counter value captured at that preceding edge. Writes, set-value pulses and narrow-mode truncation update cmp_o, period_o and setval_o at the next edge. Every input is driven at a falling edge and every output is read at a falling edge, half a clock away from any update. Catch-up takes one clock per period step, so the bench holds the counter still for more clocks than the steps it computes before it reads the comparator.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;

    localparam int unsigned TICK_W   = 64;
    localparam int unsigned NARROW_W = 32;

    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        logic periodic;
        logic narrow;
    } mode_t;

    typedef struct packed {
        logic  load_cmp;
        logic  load_per;
        tick_t value;
    } wr_res_t;

    // Bits that take part at the active width.
    function automatic tick_t width_mask(input logic narrow);
        tick_t m;
        m = '1;
        if (narrow) m[TICK_W-1:NARROW_W] = '0;
        return m;
    endfunction

    // The sign bit at the active width.
    function automatic tick_t sign_bit(input logic narrow);
        tick_t b;
        b = '0;
        b[narrow ? NARROW_W-1 : TICK_W-1] = 1'b1;
        return b;
    endfunction

    // True when a lies strictly after b (wrap-aware).
    function automatic logic is_ahead(input tick_t a, input tick_t b, input logic narrow);
        tick_t d;
        d = b - a;
        return (d & sign_bit(narrow)) != '0;
    endfunction

endpackage

// File: rtl/cmpch_wr.sv
module cmpch_wr
    import cmpch_pkg::*;
#(
    parameter int unsigned MIN_PERIOD = 12886
) (
    input  mode_t   mode_i,
    input  logic    setval_i,
    input  tick_t   wdata_i,
    output wr_res_t res_o
);
    localparam tick_t MIN_TICKS = tick_t'(MIN_PERIOD);

    tick_t data_m;
    tick_t per_v;

    always_comb begin
        data_m = wdata_i & width_mask(mode_i.narrow);
        per_v  = data_m & ~sign_bit(mode_i.narrow);
        if (per_v < MIN_TICKS) per_v = MIN_TICKS;
        res_o.load_cmp = !mode_i.periodic || setval_i;
        res_o.load_per = mode_i.periodic && !setval_i;
        res_o.value    = (!mode_i.periodic || setval_i) ? data_m : per_v;
    end
endmodule

// File: rtl/cmpch_hit.sv
module cmpch_hit
    import cmpch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run_i,
    input  logic  narrow_i,
    input  logic  catch_i,
    input  tick_t count_i,
    input  tick_t cmp_i,
    output logic  fire_now_o,
    output logic  fire_o
);
    logic match;
    logic hit_q;

    assign match      = ((count_i ^ cmp_i) & width_mask(narrow_i)) == '0;
    assign fire_now_o = run_i && match && !hit_q && !catch_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            fire_o <= 1'b0;
        end else begin
            hit_q  <= match && (hit_q || fire_now_o);
            fire_o <= fire_now_o;
        end
    end
endmodule

// File: rtl/cmpch_step.sv
module cmpch_step
    import cmpch_pkg::*;
(
    input  mode_t mode_i,
    input  logic  fire_now_i,
    input  logic  catch_i,
    input  tick_t cmp_i,
    input  tick_t period_i,
    input  tick_t count_i,
    output tick_t cmp_o,
    output logic  catch_o
);
    tick_t sum;

    always_comb begin
        sum     = (cmp_i + period_i) & width_mask(mode_i.narrow);
        cmp_o   = cmp_i;
        catch_o = catch_i;
        if (catch_i) begin
            if (is_ahead(cmp_i, count_i, mode_i.narrow)) begin
                catch_o = 1'b0;
            end else begin
                cmp_o = sum;
            end
        end else if (fire_now_i && mode_i.periodic && (period_i != '0)) begin
            cmp_o   = sum;
            catch_o = 1'b1;
        end
    end
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmpch_pkg::*;
#(
    parameter int unsigned MIN_PERIOD = 12886
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              periodic_i,
    input  logic              narrow_i,
    input  logic              setval_i,
    input  logic              cmp_wr_i,
    input  logic [TICK_W-1:0] cmp_wdata_i,
    input  logic [TICK_W-1:0] count_i,
    output logic              fire_o,
    output logic              setval_o,
    output logic [TICK_W-1:0] cmp_o,
    output logic [TICK_W-1:0] period_o
);
    mode_t   mode;
    wr_res_t wr;
    tick_t   cmp_q, per_q, cmp_d, per_d, step_cmp;
    logic    setval_q, setval_d, catch_q, catch_d, step_catch, fire_now;

    assign mode.periodic = periodic_i;
    assign mode.narrow   = narrow_i;

    cmpch_wr #(.MIN_PERIOD(MIN_PERIOD)) u_wr (
        .mode_i   (mode),
        .setval_i (setval_q),
        .wdata_i  (cmp_wdata_i),
        .res_o    (wr)
    );

    cmpch_hit u_hit (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run_i),
        .narrow_i   (narrow_i),
        .catch_i    (catch_q),
        .count_i    (count_i),
        .cmp_i      (cmp_q),
        .fire_now_o (fire_now),
        .fire_o     (fire_o)
    );

    cmpch_step u_step (
        .mode_i     (mode),
        .fire_now_i (fire_now),
        .catch_i    (catch_q),
        .cmp_i      (cmp_q),
        .period_i   (per_q),
        .count_i    (count_i),
        .cmp_o      (step_cmp),
        .catch_o    (step_catch)
    );

    always_comb begin
        cmp_d    = step_cmp;
        catch_d  = step_catch;
        per_d    = per_q;
        setval_d = setval_q | setval_i;
        if (cmp_wr_i) begin
            setval_d = 1'b0;
            if (wr.load_cmp) begin
                cmp_d   = wr.value;
                catch_d = 1'b0;
            end
            if (wr.load_per) per_d = wr.value;
        end
        cmp_d = cmp_d & width_mask(narrow_i);
        per_d = per_d & width_mask(narrow_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q    <= '1;
            per_q    <= '0;
            setval_q <= 1'b0;
            catch_q  <= 1'b0;
        end else begin
            cmp_q    <= cmp_d;
            per_q    <= per_d;
            setval_q <= setval_d;
            catch_q  <= catch_d;
        end
    end

    assign cmp_o    = cmp_q;
    assign period_o = per_q;
    assign setval_o = setval_q;
endmodule

// File: rtl/cmp_channel_chk.sv
module cmp_channel_chk
    import cmpch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run_i,
    input logic              narrow_i,
    input logic              cmp_wr_i,
    input logic              fire_o,
    input logic              setval_o,
    input logic              catch_q,
    input logic [TICK_W-1:0] cmp_o,
    input logic [TICK_W-1:0] period_o
);
    // R2: the event lasts a single clock
    a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);

    // R4: stopped channel stays silent
    a_r4_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !fire_o);

    // R7: every comparator write clears set-value
    a_r7_setval_cleared: assert property (@(posedge clk) disable iff (rst)
        cmp_wr_i |=> !setval_o);

    // R9: narrow mode keeps upper halves at zero
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        narrow_i |=> (cmp_o[TICK_W-1:NARROW_W] == '0) && (period_o[TICK_W-1:NARROW_W] == '0));

    // R6: the stored period never has its top bit set
    a_r6_period_top_clear: assert property (@(posedge clk) disable iff (rst)
        period_o[TICK_W-1] == 1'b0);

    // R8: no event while the comparator is catching up
    a_r8_silent_catchup: assert property (@(posedge clk) disable iff (rst)
        catch_q |=> !fire_o);
endmodule

bind cmp_channel cmp_channel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_i),
    .narrow_i (narrow_i),
    .cmp_wr_i (cmp_wr_i),
    .fire_o   (fire_o),
    .setval_o (setval_o),
    .catch_q  (catch_q),
    .cmp_o    (cmp_o),
    .period_o (period_o)
);

// File: tb/sim_cmp_channel.sv
`timescale 1ns/1ps
module sim_cmp_channel;
    localparam int unsigned MINP = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 1'b0, periodic_i = 1'b0, narrow_i = 1'b0;
    logic        setval_i = 1'b0, cmp_wr_i = 1'b0;
    logic [63:0] cmp_wdata_i = '0, count_i = '0;
    logic        fire_o, setval_o;
    logic [63:0] cmp_o, period_o;

    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [63:0] seen_cnt = '0;
    logic [63:0] exp_q[$];

    always #2.5 clk = ~clk;

    cmp_channel #(.MIN_PERIOD(MINP)) u0 (
        .clk(clk), .rst(rst), .run_i(run_i), .periodic_i(periodic_i),
        .narrow_i(narrow_i), .setval_i(setval_i), .cmp_wr_i(cmp_wr_i),
        .cmp_wdata_i(cmp_wdata_i), .count_i(count_i), .fire_o(fire_o),
        .setval_o(setval_o), .cmp_o(cmp_o), .period_o(period_o)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic expect_fire(input logic [63:0] c);
        exp_q.push_back(c);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cmp(input logic [63:0] v);
        cmp_wr_i = 1'b1;
        cmp_wdata_i = v;
        @(negedge clk);
        cmp_wr_i = 1'b0;
    endtask

    task automatic pulse_setval();
        setval_i = 1'b1;
        @(negedge clk);
        setval_i = 1'b0;
    endtask

    task automatic sweep(input logic [63:0] from, input logic [63:0] upto);
        for (logic [63:0] v = from; v <= upto; v++) begin
            count_i = v;
            @(negedge clk);
        end
    endtask

    // monitor: pop an expected counter value per event
    always @(posedge clk) seen_cnt <= count_i;

    always @(negedge clk) begin
        if (!rst && fire_o) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected event got=%h exp=none", seen_cnt);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                if (e !== seen_cnt) begin
                    fails++;
                    $display("FAIL R2 event at count got=%h exp=%h", seen_cnt, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=timeout exp=finish");
        finish_run();
    end

    initial begin
        logic [63:0] c;
        wait_n(3);
        rst = 1'b0;
        // R1 reset values
        check("R1 cmp", cmp_o, '1);
        check("R1 period", period_o, '0);
        check("R1 setval", {63'd0, setval_o}, 64'd0);
        check("R1 fire", {63'd0, fire_o}, 64'd0);

        // R2 / R5: one-shot wide compare
        run_i = 1'b1;
        wr_cmp(64'd20);
        check("R5 load", cmp_o, 64'd20);
        expect_fire(64'd20);
        sweep(64'd1, 64'd40);
        check("R5 one-shot keeps", cmp_o, 64'd20);

        // R3: held counter fires once
        count_i = 64'd50;
        wr_cmp(64'd50);
        expect_fire(64'd50);
        wait_n(10);

        // R4: stopped, then re-armed
        run_i = 1'b0;
        wr_cmp(64'd70);
        sweep(64'd60, 64'd75);
        count_i = 64'd80;
        wr_cmp(64'd80);
        wait_n(3);
        expect_fire(64'd80);
        run_i = 1'b1;
        wait_n(3);

        // R7 / R8: periodic with zero period
        periodic_i = 1'b1;
        pulse_setval();
        check("R7 set", {63'd0, setval_o}, 64'd1);
        wr_cmp(64'd85);
        check("R7 cleared", {63'd0, setval_o}, 64'd0);
        check("R5 setval load", cmp_o, 64'd85);
        expect_fire(64'd85);
        sweep(64'd81, 64'd95);
        check("R8 zero period holds", cmp_o, 64'd85);

        // R6 / R8: period write and recurring events
        pulse_setval();
        wr_cmp(64'd100);
        wr_cmp(64'd30);
        check("R6 period", period_o, 64'd30);
        check("R6 cmp untouched", cmp_o, 64'd100);
        expect_fire(64'd100);
        expect_fire(64'd130);
        expect_fire(64'd160);
        expect_fire(64'd190);
        sweep(64'd96, 64'd200);
        check("R8 advanced", cmp_o, 64'd220);

        // R6: floor and top bit
        wr_cmp(64'd5);
        check("R6 floor", period_o, 64'd16);
        wr_cmp(64'h8000_0000_0000_0040);
        check("R6 top bit", period_o, 64'h40);

        // R8: catch-up after a counter jump
        wr_cmp(64'd16);
        pulse_setval();
        wr_cmp(64'd300);
        expect_fire(64'd300);
        count_i = 64'd300;
        @(negedge clk);
        count_i = 64'd350;
        wait_n(6);
        c = 64'd300;
        while (c <= 64'd350) c += 64'd16;
        check("R8 catch-up", cmp_o, c);
        expect_fire(c);
        sweep(64'd351, c);
        wait_n(2);

        // R9: narrow truncation
        pulse_setval();
        wr_cmp(64'h1_0000_0010);
        wr_cmp(64'h1_0000_0020);
        check("R6 wide period", period_o, 64'h1_0000_0020);
        narrow_i = 1'b1;
        @(negedge clk);
        check("R9 cmp trunc", cmp_o, 64'h10);
        check("R9 period trunc", period_o, 64'h20);
        pulse_setval();
        wr_cmp(64'hFFFF_FFFF_0000_0040);
        check("R9 write trunc", cmp_o, 64'h40);
        wr_cmp(64'h8000_0050);
        check("R9 period bit31", period_o, 64'h50);

        // R9: 32-bit wrap of compare and advance
        pulse_setval();
        wr_cmp(64'hFFFF_FFF8);
        expect_fire(64'h5_FFFF_FFF8);
        expect_fire(64'h6_0000_0048);
        sweep(64'h5_FFFF_FFF0, 64'h6_0000_0050);
        check("R9 wrapped cmp", cmp_o, 64'h98);

        wait_n(3);
        check("R2 all events seen", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule